// File: doc/BRIEF.md
# Teletext extension packet store allocator

This block turns each byte of a received teletext extension or service packet into an external-memory byte address. Each acquisition channel owns a 1 KB store: channel A uses store 0 (addresses 0x000 to 0x3FF) and channel B uses store 1 (0x400 to 0x7FF). Within a store, three 8-byte tag fields, a run of 40-byte slots for the extension packets and two fixed 40-byte regions for the broadcast service packets sit at fixed offsets.

Extension packets of types 26, 27 and 28 share one pool of slots. They are placed in arrival order, whatever their type. Each channel keeps a slot count, which a page-header pulse for that channel clears. Once 23 packets have been stored, further extension bytes are discarded. Broadcast packets 8/30 ignore the request channel and go to store 0 or store 1 according to their designation code. The block answers every request one clock later with either an address or a discard flag. Packet decoding and the DRAM cycle are left to neighbouring blocks.

Top module: `xpkt_store_alloc`

## Requirements
- R1: One cycle after a cycle with `req_valid` high, exactly one of `addr_valid` and `discard` is high. After a cycle with `req_valid` low, both are low.
- R2: Kind codes 0 (page number), 1 (time) and 2 (packet X/31) map byte index i (0..7) to store offset 0x00+i, 0x08+i and 0x10+i. An index of 8 or more is discarded.
- R3: Kind codes 3, 4 and 5 (packets 26, 27, 28) map byte index i (0..39) to offset 0x18 + 0x28*n + i. Here n is the number of extension packets the channel has completed since its last header, counted regardless of type.
- R4: When a channel has completed 23 extension packets, every further extension byte for that channel is discarded and its count stays at 23.
- R5: A channel's slot count advances by one only when byte index 39 of an accepted extension packet is written. Any other index leaves the slot unchanged.
- R6: A `hdr_valid` pulse clears the slot count of channel `hdr_chan` and leaves the other channel's count alone. When the pulse coincides with an advance on the same channel, the clear wins.
- R7: Kind code 7 (packet 8/30) maps index i (0..39) to offset 0x3D8+i. The store is set by bit 1 of `req_desig`: codes 0,1,4,5,8,9,C,D go to store 0 and codes 2,3,6,7,A,B,E,F go to store 1. `req_chan` has no effect.
- R8: Kind code 6 (packet 8/29) maps index i (0..39) to offset 0x3B0+i. An index of 40 or more is discarded.
- R9: For every kind except 7, address bit 10 equals `req_chan` (0 = channel A).
- R10: `inh_hdr` high discards kinds 0 and 1, and `inh_p29` high discards kind 6. Neither input changes the result for any other kind.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A packet byte wants an address this cycle |
| req_chan | input | 1 | Acquisition channel, 0 = A, 1 = B |
| req_kind | input | 3 | Packet kind code (see R2, R3, R7, R8) |
| req_desig | input | 4 | Designation code, used for kind 7 |
| req_idx | input | 6 | Byte index within the packet |
| hdr_valid | input | 1 | A new page header was accepted |
| hdr_chan | input | 1 | Channel of the accepted header |
| inh_hdr | input | 1 | Suppress page number and time bytes |
| inh_p29 | input | 1 | Suppress packet 8/29 bytes |
| addr_valid | output | 1 | `addr` holds a write address |
| addr | output | 11 | Absolute byte address, bit 10 = store |
| discard | output | 1 | The previous request is dropped |

## Verification
The assertions check on every cycle that each request gets exactly one response, and that an idle cycle gets none. They also check that the slot counts never pass 23, that a count moves only by one step or by a clear, that a header clears its channel's count, and that the store bit and region of 8/30 and extension addresses are right. Only the bench's scenarios can show the exact arithmetic of each address: the slot sequence across mixed packet types, the cutoff after the 23rd packet, the independence of the two channels, the routing of all sixteen designation codes, and the effect of the inhibit inputs on the right kinds only.

// File: rtl/xsa_pkg.sv
package xsa_pkg;

  typedef enum logic [2:0] {
    PK_PGNUM = 3'd0,
    PK_TIME  = 3'd1,
    PK_X31   = 3'd2,
    PK_X26   = 3'd3,
    PK_X27   = 3'd4,
    PK_X28   = 3'd5,
    PK_P829  = 3'd6,
    PK_P830  = 3'd7
  } pkt_kind_e;

endpackage

// File: rtl/xsa_rst_sync.sv
module xsa_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/xsa_slot_ctr.sv
module xsa_slot_ctr #(
  parameter int MAX_SLOTS = 23,
  parameter int CNT_W     = $clog2(MAX_SLOTS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             adv,
  output logic [CNT_W-1:0] cnt,
  output logic             full
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign full = (cnt_q == CNT_W'(MAX_SLOTS));

  always_comb begin
    cnt_en = clr || (adv && !full);
    cnt_d  = cnt_q;
    if (clr)             cnt_d = '0;
    else if (adv && !full) cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;

endmodule

// File: rtl/xsa_addr_map.sv
module xsa_addr_map
  import xsa_pkg::*;
#(
  parameter int         PKT_BYTES  = 40,
  parameter int         TAG_BYTES  = 8,
  parameter int         STORE_AW   = 10,
  parameter int         SLOT_BASE  = 24,
  parameter int         P829_OFS   = 944,
  parameter int         P830_OFS   = 984,
  parameter logic [3:0] STORE_MASK = 4'b0010,
  parameter int         IDX_W      = 6,
  parameter int         CNT_W      = 5
) (
  input  logic [2:0]          kind,
  input  logic [IDX_W-1:0]    idx,
  input  logic [3:0]          desig,
  input  logic                chan,
  input  logic [CNT_W-1:0]    cnt,
  input  logic                full,
  input  logic                inh_hdr,
  input  logic                inh_p29,
  output logic                accept,
  output logic                is_ext,
  output logic [STORE_AW:0]   addr
);

  localparam logic [IDX_W-1:0] TAG_LIM = IDX_W'(TAG_BYTES);
  localparam logic [IDX_W-1:0] PKT_LIM = IDX_W'(PKT_BYTES);

  pkt_kind_e           k;
  logic [STORE_AW-1:0] ofs;
  logic                store;
  logic                idx_tag_ok, idx_pkt_ok;

  assign k          = pkt_kind_e'(kind);
  assign idx_tag_ok = (idx < TAG_LIM);
  assign idx_pkt_ok = (idx < PKT_LIM);

  always_comb begin
    ofs    = '0;
    store  = chan;
    accept = 1'b0;
    is_ext = 1'b0;
    unique case (k)
      PK_PGNUM, PK_TIME, PK_X31: begin
        ofs    = STORE_AW'(kind) * STORE_AW'(TAG_BYTES) + STORE_AW'(idx);
        accept = idx_tag_ok && !(inh_hdr && (k != PK_X31));
      end
      PK_X26, PK_X27, PK_X28: begin
        is_ext = 1'b1;
        ofs    = STORE_AW'(SLOT_BASE) + STORE_AW'(cnt) * STORE_AW'(PKT_BYTES)
               + STORE_AW'(idx);
        accept = idx_pkt_ok && !full;
      end
      PK_P829: begin
        ofs    = STORE_AW'(P829_OFS) + STORE_AW'(idx);
        accept = idx_pkt_ok && !inh_p29;
      end
      PK_P830: begin
        ofs    = STORE_AW'(P830_OFS) + STORE_AW'(idx);
        store  = |(desig & STORE_MASK);
        accept = idx_pkt_ok;
      end
      default: ;
    endcase
  end

  assign addr = {store, ofs};

endmodule

// File: rtl/xpkt_store_alloc.sv
module xpkt_store_alloc #(
  parameter int         PKT_BYTES   = 40,
  parameter int         MAX_SLOTS   = 23,
  parameter int         TAG_BYTES   = 8,
  parameter int         STORE_AW    = 10,
  parameter int         SLOT_BASE   = 24,
  parameter int         P829_OFS    = 944,
  parameter logic [3:0] STORE_MASK  = 4'b0010
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic                req_chan,
  input  logic [2:0]          req_kind,
  input  logic [3:0]          req_desig,
  input  logic [5:0]          req_idx,
  input  logic                hdr_valid,
  input  logic                hdr_chan,
  input  logic                inh_hdr,
  input  logic                inh_p29,
  output logic                addr_valid,
  output logic [STORE_AW:0]   addr,
  output logic                discard
);

  localparam int STORE_BYTES = 1 << STORE_AW;
  localparam int P830_OFS    = STORE_BYTES - PKT_BYTES;
  localparam int IDX_W       = 6;
  localparam int CNT_W       = $clog2(MAX_SLOTS + 1);
  localparam int NCHAN       = 2;

  logic                         rst_q_n;
  logic [NCHAN-1:0][CNT_W-1:0]  slot_cnt;
  logic [NCHAN-1:0]             slot_full;
  logic [NCHAN-1:0]             slot_clr, slot_adv;
  logic                         map_accept, map_is_ext;
  logic [STORE_AW:0]            map_addr;
  logic                         last_byte;

  logic                         addr_valid_q, addr_valid_d;
  logic                         discard_q, discard_d;
  logic [STORE_AW:0]            addr_q, addr_d;
  logic                         addr_en;

  xsa_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_q_n)
  );

  assign last_byte = (req_idx == IDX_W'(PKT_BYTES - 1));

  for (genvar c = 0; c < NCHAN; c++) begin : g_chan
    assign slot_clr[c] = hdr_valid && (hdr_chan == c[0]);
    assign slot_adv[c] = req_valid && map_accept && map_is_ext && last_byte
                         && (req_chan == c[0]);
    xsa_slot_ctr #(
      .MAX_SLOTS (MAX_SLOTS),
      .CNT_W     (CNT_W)
    ) u_ctr (
      .clk   (clk),
      .rst_n (rst_q_n),
      .clr   (slot_clr[c]),
      .adv   (slot_adv[c]),
      .cnt   (slot_cnt[c]),
      .full  (slot_full[c])
    );
  end

  xsa_addr_map #(
    .PKT_BYTES  (PKT_BYTES),
    .TAG_BYTES  (TAG_BYTES),
    .STORE_AW   (STORE_AW),
    .SLOT_BASE  (SLOT_BASE),
    .P829_OFS   (P829_OFS),
    .P830_OFS   (P830_OFS),
    .STORE_MASK (STORE_MASK),
    .IDX_W      (IDX_W),
    .CNT_W      (CNT_W)
  ) u_map (
    .kind    (req_kind),
    .idx     (req_idx),
    .desig   (req_desig),
    .chan    (req_chan),
    .cnt     (slot_cnt[req_chan]),
    .full    (slot_full[req_chan]),
    .inh_hdr (inh_hdr),
    .inh_p29 (inh_p29),
    .accept  (map_accept),
    .is_ext  (map_is_ext),
    .addr    (map_addr)
  );

  always_comb begin
    addr_valid_d = req_valid && map_accept;
    discard_d    = req_valid && !map_accept;
    addr_en      = req_valid && map_accept;
    addr_d       = map_addr;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      addr_valid_q <= 1'b0;
      discard_q    <= 1'b0;
    end else begin
      addr_valid_q <= addr_valid_d;
      discard_q    <= discard_d;
    end
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n)     addr_q <= '0;
    else if (addr_en) addr_q <= addr_d;
  end

  assign addr_valid = addr_valid_q;
  assign discard    = discard_q;
  assign addr       = addr_q;

endmodule

// File: rtl/xsa_chk.sv
module xsa_chk #(
  parameter int         MAX_SLOTS  = 23,
  parameter int         CNT_W      = 5,
  parameter int         STORE_AW   = 10,
  parameter int         SLOT_BASE  = 24,
  parameter int         P829_OFS   = 944,
  parameter int         P830_OFS   = 984,
  parameter logic [3:0] STORE_MASK = 4'b0010
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   req_valid,
  input logic [2:0]             req_kind,
  input logic [3:0]             req_desig,
  input logic                   hdr_valid,
  input logic                   hdr_chan,
  input logic                   addr_valid,
  input logic                   discard,
  input logic [STORE_AW:0]      addr,
  input logic [1:0][CNT_W-1:0]  slot_cnt
);

  // R1
  one_answer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (addr_valid ^ discard));

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!addr_valid && !discard));

  // R4
  cap_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    slot_cnt[0] <= CNT_W'(MAX_SLOTS));

  // R4
  cap_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
    slot_cnt[1] <= CNT_W'(MAX_SLOTS));

  // R5
  step_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_cnt[0] != $past(slot_cnt[0])) |->
      (slot_cnt[0] == '0 || slot_cnt[0] == $past(slot_cnt[0]) + CNT_W'(1)));

  // R6
  hdr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_valid |=> (slot_cnt[$past(hdr_chan)] == '0));

  // R7
  bcast_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_kind == 3'd7) |=>
      (!addr_valid || (addr[STORE_AW] == $past(|(req_desig & STORE_MASK))
                       && addr[STORE_AW-1:0] >= STORE_AW'(P830_OFS))));

  // R3
  ext_region_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_kind >= 3'd3 && req_kind <= 3'd5) |=>
      (!addr_valid || (addr[STORE_AW-1:0] >= STORE_AW'(SLOT_BASE)
                       && addr[STORE_AW-1:0] < STORE_AW'(P829_OFS))));

endmodule

bind xpkt_store_alloc xsa_chk #(
  .MAX_SLOTS  (MAX_SLOTS),
  .CNT_W      (CNT_W),
  .STORE_AW   (STORE_AW),
  .SLOT_BASE  (SLOT_BASE),
  .P829_OFS   (P829_OFS),
  .P830_OFS   (P830_OFS),
  .STORE_MASK (STORE_MASK)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_q_n),
  .req_valid  (req_valid),
  .req_kind   (req_kind),
  .req_desig  (req_desig),
  .hdr_valid  (hdr_valid),
  .hdr_chan   (hdr_chan),
  .addr_valid (addr_valid),
  .discard    (discard),
  .addr       (addr),
  .slot_cnt   (slot_cnt)
);

// File: tb/sim_xpkt_store_alloc.sv
module sim_xpkt_store_alloc;

  logic        clk;
  logic        rst_n;
  logic        req_valid, req_chan, hdr_valid, hdr_chan, inh_hdr, inh_p29;
  logic [2:0]  req_kind;
  logic [3:0]  req_desig;
  logic [5:0]  req_idx;
  logic        addr_valid, discard;
  logic [10:0] addr;

  int errors = 0;
  int checks = 0;
  int cnt_m [2];
  bit done = 0;

  xpkt_store_alloc u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_chan(req_chan),
    .req_kind(req_kind), .req_desig(req_desig), .req_idx(req_idx),
    .hdr_valid(hdr_valid), .hdr_chan(hdr_chan), .inh_hdr(inh_hdr),
    .inh_p29(inh_p29), .addr_valid(addr_valid), .addr(addr), .discard(discard)
  );

  initial clk = 0;
  always #2.5 clk = ~clk;

  task automatic check(input string req, input logic [12:0] act, input logic [12:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got v=%0b d=%0b a=%h, expected v=%0b d=%0b a=%h",
               req, act[12], act[11], act[10:0], exp[12], exp[11], exp[10:0]);
    end
  endtask

  // one request cycle, optional header pulse, checked one cycle later
  task automatic step(input string req, input bit v, input int kind, input bit ch,
                      input int dg, input int idx, input bit hv, input bit hc);
    bit ok, ext, st;
    int ofs;
    ok = 0; ext = 0; st = ch; ofs = 0;
    if (kind <= 2) begin
      ok  = (idx < 8) && !(inh_hdr && kind < 2);
      ofs = kind * 8 + idx;
    end else if (kind <= 5) begin
      ext = 1;
      ok  = (idx < 40) && (cnt_m[ch] < 23);
      ofs = 24 + 40 * cnt_m[ch] + idx;
    end else if (kind == 6) begin
      ok  = (idx < 40) && !inh_p29;
      ofs = 'h3B0 + idx;
    end else begin
      ok  = (idx < 40);
      ofs = 'h3D8 + idx;
      st  = (dg == 2 || dg == 3 || dg == 6 || dg == 7 ||
             dg == 10 || dg == 11 || dg == 14 || dg == 15);
    end
    @(negedge clk);
    req_valid = v; req_kind = 3'(kind); req_chan = ch; req_desig = 4'(dg);
    req_idx = 6'(idx); hdr_valid = hv; hdr_chan = hc;
    @(posedge clk);
    if (v && ok && ext && idx == 39 && !(hv && hc == ch)) cnt_m[ch]++;
    if (hv) cnt_m[hc] = 0;
    #1;
    if (!v)
      check(req, {addr_valid, discard, 11'h0}, 13'h0);
    else if (ok)
      check(req, {addr_valid, discard, addr}, {1'b1, 1'b0, st, 10'(ofs)});
    else
      check(req, {addr_valid, discard, 11'h0}, {1'b0, 1'b1, 11'h0});
  endtask

  task automatic ext_pkt(input string req, input int kind, input bit ch);
    for (int i = 0; i < 40; i++) step(req, 1, kind, ch, 0, i, 0, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run hung, got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 0; req_valid = 0; req_chan = 0; req_kind = 0; req_desig = 0;
    req_idx = 0; hdr_valid = 0; hdr_chan = 0; inh_hdr = 0; inh_p29 = 0;
    cnt_m[0] = 0; cnt_m[1] = 0;
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset", {addr_valid, discard, addr}, 13'h0);
    @(negedge clk) rst_n = 1;
    repeat (4) @(posedge clk);

    // R1 idle cycles
    for (int i = 0; i < 3; i++) step("R1 idle", 0, 0, 0, 0, 0, 0, 0);

    // R2 R9 tag fields, both channels, indices up to 9
    for (int c = 0; c < 2; c++)
      for (int k = 0; k < 3; k++)
        for (int i = 0; i < 10; i++) step("R2 R9 tag", 1, k, c[0], 0, i, 0, 0);

    // R10 inhibits
    inh_hdr = 1;
    for (int k = 0; k < 3; k++) step("R10 inh_hdr", 1, k, 0, 0, 3, 0, 0);
    step("R10 inh_hdr vs 8/29", 1, 6, 1, 0, 5, 0, 0);
    inh_hdr = 0; inh_p29 = 1;
    step("R10 inh_p29", 1, 6, 0, 0, 5, 0, 0);
    step("R10 inh_p29 vs tag", 1, 0, 0, 0, 5, 0, 0);
    step("R10 inh_p29 vs 8/30", 1, 7, 0, 0, 5, 0, 0);
    inh_p29 = 0;

    // R8 8/29 sweep incl. out-of-range
    for (int c = 0; c < 2; c++)
      for (int i = 0; i < 42; i++) step("R8 R9 p829", 1, 6, c[0], 0, i, 0, 0);

    // R7 8/30, all designation codes, both channels
    for (int c = 0; c < 2; c++)
      for (int d = 0; d < 16; d++) begin
        step("R7 p830", 1, 7, c[0], d, 0, 0, 0);
        step("R7 p830", 1, 7, c[0], d, 39, 0, 0);
        step("R7 p830 range", 1, 7, c[0], d, 40, 0, 0);
      end

    // R3 R4 channel A fills 25 packets of mixed kinds, B interleaved once
    for (int p = 0; p < 25; p++) begin
      ext_pkt("R3 R4 ext A", 3 + (p % 3), 0);
      if (p == 5) ext_pkt("R3 R9 ext B", 5, 1);
    end
    step("R3 ext B after A full", 1, 4, 1, 0, 0, 0, 0);

    // R6 header clears A only
    step("R6 hdr A", 0, 0, 0, 0, 0, 1, 0);
    step("R6 A restarts", 1, 3, 0, 0, 0, 0, 0);
    step("R6 B kept", 1, 3, 1, 0, 0, 0, 0);

    // R5 partial packet does not advance; index 40 discarded
    for (int i = 0; i < 20; i++) step("R5 partial", 1, 4, 0, 0, i, 0, 0);
    step("R5 idx40", 1, 4, 0, 0, 40, 0, 0);
    step("R5 same slot", 1, 5, 0, 0, 7, 0, 0);
    step("R5 last", 1, 5, 0, 0, 39, 0, 0);
    step("R5 next slot", 1, 3, 0, 0, 0, 0, 0);

    // R6 header wins against coincident advance
    step("R6 clash", 1, 3, 0, 0, 39, 1, 0);
    step("R6 after clash", 1, 3, 0, 0, 1, 0, 0);
    step("R6 hdr B", 0, 0, 0, 0, 0, 1, 1);
    step("R6 B cleared", 1, 5, 1, 0, 2, 0, 0);
    step("R1 idle end", 0, 0, 0, 0, 0, 0, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule